// File: doc/BRIEF.md
# Peripheral reset and enable controller

This block is a small register window that software uses to control reset and clock-enable lines for a set of peripherals. A simple register bus carries 32-bit words and a byte offset. Each control word drives 32 output lines. The window has one range of reset control words and one range of enable control words, and each range has one word per bus group. All other words in the window are plain storage.

The output lines do not follow the register contents. When a control word is written, the block compares each bit of the new word with the stored word:
- A reset line drops to 0 when its bit changes from one to zero.
- An enable line rises to 1 when its bit changes from zero to one.
- Any other bit change leaves the line as it was.

After a block reset, all reset lines are asserted and all enable lines are off. Software releases and enables peripherals by writing patterns to the control words. Reads return the stored words one cycle after the request.

Top module: `periph_gate_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, every window word reads 0, every bit of `rst_lines` is 1 and every bit of `ena_lines` is 0.
- R2: The word index is `addr >> 2`. A read with `rd_en` high presents the addressed word on `rdata` one cycle later. The window holds NREGS words, 24 by default (word indices 0 to 23).
- R3: A read of a word index at or above NREGS returns 0. A write to such an index changes no stored word and no output line.
- R4: Reset control word k sits at word index RST_BASE+k (default 4, so byte offsets 0x10 to 0x20). For bit i of word k, `rst_lines[32*k+i]` becomes 0 only when that bit goes from 1 to 0. A zero-to-one change does not set the line back to 1.
- R5: Enable control word k sits at word index ENA_BASE+k (default 12, so byte offsets 0x30 to 0x40). For bit i of word k, `ena_lines[32*k+i]` becomes 1 only when that bit goes from 0 to 1. A one-to-zero change does not clear the line.
- R6: A write to any in-range word outside both control ranges stores the value and leaves every output line unchanged.
- R7: The block evaluates all 32 bits of one write together. Every affected line changes on the clock edge that samples the write strobe. Without a write, the lines hold their values.
- R8: If a read and a write target the same word in the same cycle, the read returns the value stored before the write.
- R9: The two lowest address bits are ignored. Offsets 0x13 and 0x10 select the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read request for one cycle |
| addr | input | ADDR_W (8) | Byte offset into the window |
| wdata | input | 32 | Word to write |
| rdata | output | 32 | Read result, valid one cycle after `rd_en` |
| rst_lines | output | 32*GROUPS (160) | Per-peripheral reset lines, active high |
| ena_lines | output | 32*GROUPS (160) | Per-peripheral clock-enable lines |

## Verification
The assertions check these rules on every cycle:
- Reset lines never rise while the block is out of reset.
- Enable lines never fall while the block is out of reset.
- No line moves in a cycle that follows no write, or a write outside the control ranges.
- Out-of-range reads return zero.

Some behaviours depend on which bit changed and what was stored before, so only the bench scenarios can show them. These are the exact line positions hit by each falling or rising bit, read-back latency, read-before-write ordering, and aliasing of the low address bits. The bench checks these against a reference model.

// File: rtl/periph_gate_pkg.sv
package periph_gate_pkg;
  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_PLAIN = 2'd1,
    KIND_RST   = 2'd2,
    KIND_ENA   = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/periph_gate_decode.sv
module periph_gate_decode
  import periph_gate_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NREGS    = 24,
  parameter int GROUPS   = 5,
  parameter int RST_BASE = 4,
  parameter int ENA_BASE = 12,
  localparam int IDX_W   = ADDR_W - 2,
  localparam int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output slot_kind_e        kind,
  output logic [GRP_W-1:0]  grp
);
  localparam logic [IDX_W-1:0] LIMIT   = IDX_W'(NREGS);
  localparam logic [IDX_W-1:0] RST_LO  = IDX_W'(RST_BASE);
  localparam logic [IDX_W-1:0] RST_HI  = IDX_W'(RST_BASE + GROUPS);
  localparam logic [IDX_W-1:0] ENA_LO  = IDX_W'(ENA_BASE);
  localparam logic [IDX_W-1:0] ENA_HI  = IDX_W'(ENA_BASE + GROUPS);

  logic [IDX_W-1:0] rel_rst;
  logic [IDX_W-1:0] rel_ena;

  // Byte offset to word index: low two bits never take part.
  assign idx      = addr[ADDR_W-1:2];
  assign in_range = (idx < LIMIT);
  assign rel_rst  = idx - RST_LO;
  assign rel_ena  = idx - ENA_LO;

  always_comb begin
    kind = KIND_PLAIN;
    grp  = '0;
    if (!in_range) begin
      kind = KIND_NONE;
    end else if (idx >= RST_LO && idx < RST_HI) begin
      kind = KIND_RST;
      grp  = rel_rst[GRP_W-1:0];
    end else if (idx >= ENA_LO && idx < ENA_HI) begin
      kind = KIND_ENA;
      grp  = rel_ena[GRP_W-1:0];
    end
  end
endmodule

// File: rtl/periph_gate_regfile.sv
module periph_gate_regfile
  import periph_gate_pkg::*;
#(
  parameter int NREGS  = 24,
  parameter int IDX_W  = 6,
  localparam int SLOT_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  logic             rd_en,
  input  logic             in_range,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            old_word,
  output word_t            rdata
);
  word_t             store [NREGS];
  logic [SLOT_W-1:0] slot;

  assign slot = idx[SLOT_W-1:0];

  // Current content of the addressed word, used for bit comparison.
  always_comb begin
    old_word = '0;
    if (in_range) old_word = store[slot];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NREGS; n++) store[n] <= '0;
    end else if (wr_ok) begin
      store[slot] <= wdata;
    end
  end

  // Registered read port; sees the pre-write value on a collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= in_range ? store[slot] : '0;
    end
  end
endmodule

// File: rtl/periph_gate_linebank.sv
module periph_gate_linebank
  import periph_gate_pkg::*;
#(
  parameter int   GROUPS      = 5,
  parameter bit   RISE_FIRES  = 1'b0,
  parameter bit   RESET_LEVEL = 1'b1,
  localparam int  GRP_W       = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int  LINES       = WORD_W * GROUPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [GRP_W-1:0] grp,
  input  word_t            old_word,
  input  word_t            new_word,
  output logic [LINES-1:0] lines
);
  word_t fire;

  // One polarity per instance: rising bits set, or falling bits clear.
  generate
    if (RISE_FIRES) begin : g_rise
      assign fire = ~old_word & new_word;
    end else begin : g_fall
      assign fire = old_word & ~new_word;
    end
  endgenerate

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    word_t q;
    logic  sel;
    assign sel = hit && (grp == GRP_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= {WORD_W{RESET_LEVEL}};
      end else if (sel) begin
        if (RISE_FIRES) q <= q | fire;
        else            q <= q & ~fire;
      end
    end

    assign lines[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl
  import periph_gate_pkg::*;
#(
  parameter int  ADDR_W   = 8,
  parameter int  NREGS    = 24,
  parameter int  GROUPS   = 5,
  parameter int  RST_BASE = 4,
  parameter int  ENA_BASE = 12,
  localparam int LINES    = 32 * GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [LINES-1:0]  rst_lines,
  output logic [LINES-1:0]  ena_lines
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  slot_kind_e       kind;
  logic [GRP_W-1:0] grp;
  logic             wr_ok;
  word_t            old_word;

  periph_gate_decode #(
    .ADDR_W(ADDR_W), .NREGS(NREGS), .GROUPS(GROUPS),
    .RST_BASE(RST_BASE), .ENA_BASE(ENA_BASE)
  ) u_decode (
    .addr(addr), .idx(idx), .in_range(in_range), .kind(kind), .grp(grp)
  );

  assign wr_ok = wr_en && in_range;

  periph_gate_regfile #(.NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd_en(rd_en), .in_range(in_range),
    .idx(idx), .wdata(wdata), .old_word(old_word), .rdata(rdata)
  );

  periph_gate_linebank #(.GROUPS(GROUPS), .RISE_FIRES(1'b0), .RESET_LEVEL(1'b1)) u_rst_bank (
    .clk(clk), .rst(rst), .hit(wr_ok && kind == KIND_RST), .grp(grp),
    .old_word(old_word), .new_word(wdata), .lines(rst_lines)
  );

  periph_gate_linebank #(.GROUPS(GROUPS), .RISE_FIRES(1'b1), .RESET_LEVEL(1'b0)) u_ena_bank (
    .clk(clk), .rst(rst), .hit(wr_ok && kind == KIND_ENA), .grp(grp),
    .old_word(old_word), .new_word(wdata), .lines(ena_lines)
  );
endmodule

// File: rtl/periph_gate_ctrl_chk.sv
module periph_gate_ctrl_chk #(
  parameter int  ADDR_W   = 8,
  parameter int  NREGS    = 24,
  parameter int  GROUPS   = 5,
  parameter int  RST_BASE = 4,
  parameter int  ENA_BASE = 12,
  localparam int LINES    = 32 * GROUPS
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [LINES-1:0]  rst_lines,
  input logic [LINES-1:0]  ena_lines
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] widx;
  logic             ctl_hit;
  assign widx    = addr[ADDR_W-1:2];
  assign ctl_hit = (widx >= IDX_W'(RST_BASE) && widx < IDX_W'(RST_BASE + GROUPS)) ||
                   (widx >= IDX_W'(ENA_BASE) && widx < IDX_W'(ENA_BASE + GROUPS));

  // R4: a reset line never goes back to 1 outside block reset
  a_r4_rst_never_rises: assert property (@(posedge clk) disable iff (rst)
    (rst_lines & ~$past(rst_lines)) == '0);

  // R5: an enable line never drops outside block reset
  a_r5_ena_never_falls: assert property (@(posedge clk) disable iff (rst)
    (~ena_lines & $past(ena_lines)) == '0);

  // R7: without a write the lines hold
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(rst_lines) && $stable(ena_lines)));

  // R6: writes outside both control ranges leave the lines alone
  a_r6_plain_no_effect: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ctl_hit) |=> ($stable(rst_lines) && $stable(ena_lines)));

  // R3: out-of-range reads return zero
  a_r3_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && widx >= IDX_W'(NREGS)) |=> (rdata == '0));
endmodule

bind periph_gate_ctrl periph_gate_ctrl_chk #(
  .ADDR_W(ADDR_W), .NREGS(NREGS), .GROUPS(GROUPS),
  .RST_BASE(RST_BASE), .ENA_BASE(ENA_BASE)
) u_chk (.*);

// File: tb/periph_gate_ctrl_bench.sv
module periph_gate_ctrl_bench;
  localparam int ADDR_W   = 8;
  localparam int NREGS    = 24;
  localparam int GROUPS   = 5;
  localparam int RST_BASE = 4;
  localparam int ENA_BASE = 12;
  localparam int LINES    = 32 * GROUPS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [LINES-1:0]  rst_lines;
  logic [LINES-1:0]  ena_lines;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0]      mdl_reg [NREGS];
  logic [LINES-1:0] mdl_rst;
  logic [LINES-1:0] mdl_ena;

  always #10 clk = ~clk;

  periph_gate_ctrl #(
    .ADDR_W(ADDR_W), .NREGS(NREGS), .GROUPS(GROUPS),
    .RST_BASE(RST_BASE), .ENA_BASE(ENA_BASE)
  ) u_periph_gate_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_lines(rst_lines), .ena_lines(ena_lines)
  );

  task automatic check(input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int n = 0; n < NREGS; n++) mdl_reg[n] = '0;
    mdl_rst = '1;
    mdl_ena = '0;
  endfunction

  function automatic void model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int k;
    logic [31:0] old;
    k = int'(a >> 2);
    if (k >= NREGS) return;
    old = mdl_reg[k];
    mdl_reg[k] = d;
    if (k >= RST_BASE && k < RST_BASE + GROUPS)
      mdl_rst[(k-RST_BASE)*32 +: 32] = mdl_rst[(k-RST_BASE)*32 +: 32] & ~(old & ~d);
    if (k >= ENA_BASE && k < ENA_BASE + GROUPS)
      mdl_ena[(k-ENA_BASE)*32 +: 32] = mdl_ena[(k-ENA_BASE)*32 +: 32] | (~old & d);
  endfunction

  function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
    int k;
    k = int'(a >> 2);
    return (k < NREGS) ? mdl_reg[k] : 32'h0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 rst_lines", rst_lines, mdl_rst);
    check("R1 ena_lines", ena_lines, mdl_ena);
  endtask

  task automatic do_write(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check({req, " rst_lines"}, rst_lines, mdl_rst);
    check({req, " ena_lines"}, ena_lines, mdl_ena);
  endtask

  task automatic do_read(input string req, input logic [ADDR_W-1:0] a);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp = model_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, LINES'(rdata), LINES'(exp));
  endtask

  task automatic do_rw_same(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    exp = model_read(a);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    model_write(a, d);
    check("R8 old value on collision", LINES'(rdata), LINES'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rst_lines after reset", rst_lines, mdl_rst);
    check("R1 ena_lines after reset", ena_lines, mdl_ena);
    for (int n = 0; n < NREGS; n++) do_read("R1 R2 word zero after reset", ADDR_W'(n*4));

    // R4: a rising bit leaves reset lines high; falling bits then clear all of group 0 together (R7)
    do_write("R4 rise ignored", 8'h10, 32'hFFFF_FFFF);
    do_write("R4 R7 all fall", 8'h10, 32'h0000_0000);
    do_write("R4 partial", 8'h14, 32'h0000_00FF);
    do_write("R4 fall bits 0..3", 8'h14, 32'h0000_00F0);
    // R5: enable group 4 rising, then falling leaves lines set
    do_write("R5 R7 rise", 8'h40, 32'hF0F0_F0F0);
    do_write("R5 fall ignored", 8'h40, 32'h0000_0000);
    do_read("R2 readback", 8'h40);
    // R6: plain word
    do_write("R6 plain", 8'h08, 32'hDEAD_BEEF);
    do_read("R6 readback plain", 8'h08);
    do_write("R6 plain high", ADDR_W'((NREGS-1)*4), 32'h1234_5678);
    do_read("R6 readback last", ADDR_W'((NREGS-1)*4));
    // R3: out-of-range
    do_write("R3 oob write", 8'hFC, 32'hFFFF_FFFF);
    do_read("R3 oob read", 8'hFC);
    do_read("R3 oob first", ADDR_W'(NREGS*4));
    do_read("R3 in-range untouched", 8'h00);
    // R9: low address bits ignored
    do_write("R9 alias write", 8'h33, 32'h0000_0003);
    do_read("R9 alias read", 8'h31);
    do_read("R9 base read", 8'h30);
    // R8: collision
    do_rw_same(8'h08, 32'h0BAD_F00D);
    do_read("R8 new value later", 8'h08);

    // Constrained random traffic, with periodic block resets
    for (int it = 0; it < 600; it++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0]       d;
      int                op;
      if (it % 150 == 0) do_reset();
      a  = ADDR_W'($urandom_range(0, 31) * 4 + $urandom_range(0, 3));
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 1) == 0) d = model_read(a) ^ (32'h1 << $urandom_range(0, 31));
      else d = $urandom();
      if (op < 5)       do_write("R4 R5 R6 random write", a, d);
      else if (op < 9)  do_read("R2 R3 random read", a);
      else              do_rw_same(a, d);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule